// File: doc/BRIEF.md
# Rotating Bank Mapper with Lockable Control

This block sits between a 68000-style CPU bus and a cartridge ROM. It keeps three byte-wide control registers: an SRAM control byte, a mode/lock byte and a bank-select byte. The CPU writes them by storing to the lowest 64 KB of cartridge space, and bits [11:8] of the address choose the register. The first 2 MB of CPU space is cut into eight 256 KB windows. Each window gets a 3-bit ROM bank number. Either every window shows the selected bank, or the windows run through the banks in a rotating linear order that starts at the selected bank.

A lock bit in the mode byte freezes all three registers until the next reset. A read in the cartridge I/O page returns the upper nibble of the bank-select byte. The block flags such a read so that the normal I/O path can be bypassed. The bus has no back-pressure: each strobe is taken in the cycle it is presented, and the block never stalls the CPU.

Top module: `rot_bank_mapper`

## Requirements
- R1: After reset the block behaves as if the registers were set to all-ones and then written in this order: 0x00 to the SRAM byte (selector 0xD), 0x00 to the bank byte (selector 0xF), 0x80 to the mode byte (selector 0xE). So `sram_map` is 0, every window holds bank 0, single-bank mode is active, writes are unlocked, and an I/O page read returns 0x0000.
- R2: A write is accepted only when `bus_addr[23:16]` is 0 and `bus_addr[11:8]` is 0xD, 0xE or 0xF. Any other selector value, or any address at or above 0x010000, leaves all registers unchanged.
- R3: While bit 7 of the mode byte is 0, every register write is ignored, including writes to the mode byte itself. A single write can clear that bit and change other mode bits; that write is applied, and it locks the registers from then on.
- R4: `sram_map` equals bit 7 of the SRAM byte.
- R5: The bank index is bits [6:4] of the bank byte. Bit 7 of that byte does not change the index. When bit 6 of the mode byte is 0, all eight windows hold the index.
- R6: When bit 6 of the mode byte is 1, window i (i = 0..7) holds (index + i) mod 8. Window i occupies bits [3i+2:3i] of `win_bank`.
- R7: A read (`bus_rd`=1) with `bus_addr[23:8]` = 0xA130 asserts `io_hit`, and `bus_rdata` = {8'h00, bank byte & 8'hF0}. Any other read, or no read, gives `io_hit`=0 and `bus_rdata`=0.
- R8: The byte written is taken as follows. A 16-bit write (`bus_wide`=1) uses `bus_wdata[7:0]`. A byte write to an odd address uses `bus_wdata[7:0]`. A byte write to an even address uses `bus_wdata[15:8]`.
- R9: `rom_bank` gives the bank of the window selected by `bus_addr[20:18]`.
- R10: The register state changes at the clock edge on which a valid write is presented. `win_bank`, `sram_map` and `rom_bank` follow the registers without a further register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 24 | CPU byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Write data, with byte lanes as in R8 |
| bus_rdata | output | 16 | Bank readback for the I/O page |
| io_hit | output | 1 | Read claimed by the bank readback |
| sram_map | output | 1 | SRAM mapped into CPU space |
| win_bank | output | 24 | Eight 3-bit window bank numbers, window 0 lowest |
| rom_bank | output | 3 | Bank of the window under the current address |

## Verification
A single write can do two things at once. Writing 0x40 to the mode byte switches the windows to linear rotation and also sets the lock. The bench provokes this with exactly that one write. It then checks that the linear mapping is visible at once, and that the following writes to the bank, mode and SRAM bytes change nothing that can be seen at the ports. A second overlap is an I/O page read made right after a write to the bank byte. That read must already return the new nibble, and with the lock set it must keep returning the old value after further writes.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  localparam logic [3:0] SEL_SRAM = 4'hD;
  localparam logic [3:0] SEL_MODE = 4'hE;
  localparam logic [3:0] SEL_BANK = 4'hF;

  // Net effect of the reset write sequence.
  localparam logic [7:0] RST_SRAM = 8'h00;
  localparam logic [7:0] RST_MODE = 8'h80;
  localparam logic [7:0] RST_BANK = 8'h00;

  localparam int UNLOCK_BIT = 7;
  localparam int LINEAR_BIT = 6;
  localparam int IDX_LSB    = 4;

  typedef struct packed {
    logic [7:0] sram;
    logic [7:0] mode;
    logic [7:0] bank;
  } rbm_regs_t;
endpackage

// File: rtl/rbm_regs.sv
module rbm_regs
  import rbm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [3:0] sel,
  input  logic [7:0] wbyte,
  output rbm_regs_t regs_q
);
  logic open;
  assign open = regs_q.mode[UNLOCK_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs_q <= '{sram: RST_SRAM, mode: RST_MODE, bank: RST_BANK};
    end else if (wr_en && open) begin
      case (sel)
        SEL_SRAM: regs_q.sram <= wbyte;
        SEL_MODE: regs_q.mode <= wbyte;
        SEL_BANK: regs_q.bank <= wbyte;
        default: ;
      endcase
    end
  end

  // R3: once locked, nothing moves
  p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !regs_q.mode[UNLOCK_BIT] |=> $stable(regs_q));

  // R2: foreign selectors do nothing
  p_bad_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel != SEL_SRAM && sel != SEL_MODE && sel != SEL_BANK) |=> $stable(regs_q));

  // R2: no strobe, no change
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));
endmodule

// File: rtl/rbm_window_map.sv
module rbm_window_map #(
  parameter int NUM_WIN = 8,
  localparam int BANK_W = $clog2(NUM_WIN)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BANK_W-1:0]         base,
  input  logic                      linear,
  output logic [NUM_WIN*BANK_W-1:0] win_bank
);
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    assign win_bank[i*BANK_W +: BANK_W] = linear ? base + BANK_W'(i) : base;

    if (i > 0) begin : g_chk
      // R5: single mode means every window agrees with window 0
      p_single_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !linear |-> win_bank[i*BANK_W +: BANK_W] == win_bank[0 +: BANK_W]);
      // R6: linear mode steps by one per window
      p_linear_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        linear |-> win_bank[i*BANK_W +: BANK_W] == win_bank[(i-1)*BANK_W +: BANK_W] + BANK_W'(1));
    end
  end
endmodule

// File: rtl/rbm_io_read.sv
module rbm_io_read #(
  parameter logic [15:0] IO_PAGE = 16'hA130
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd,
  input  logic [15:0] page,
  input  logic [3:0]  nib,
  output logic        hit,
  output logic [15:0] rdata
);
  assign hit   = rd && (page == IO_PAGE);
  assign rdata = hit ? {8'h00, nib, 4'h0} : 16'h0000;

  // R7: readback shape and silence outside the page
  p_io_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (rdata[15:8] == 8'h00 && rdata[3:0] == 4'h0));
  p_io_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> rdata == 16'h0000);
endmodule

// File: rtl/rot_bank_mapper.sv
module rot_bank_mapper
  import rbm_pkg::*;
#(
  parameter int          NUM_WIN   = 8,
  parameter int          WIN_SHIFT = 18,
  parameter logic [15:0] IO_PAGE   = 16'hA130,
  localparam int         BANK_W    = $clog2(NUM_WIN)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [23:0]               bus_addr,
  input  logic                      bus_rd,
  input  logic                      bus_wr,
  input  logic                      bus_wide,
  input  logic [15:0]               bus_wdata,
  output logic [15:0]               bus_rdata,
  output logic                      io_hit,
  output logic                      sram_map,
  output logic [NUM_WIN*BANK_W-1:0] win_bank,
  output logic [BANK_W-1:0]         rom_bank
);
  rbm_regs_t  regs_q;
  logic       low_region;
  logic       wr_en;
  logic [7:0] wbyte;
  logic       unused_bits;

  assign low_region = (bus_addr[23:16] == 8'h00);
  assign wr_en      = bus_wr && low_region;
  assign wbyte      = (bus_wide || bus_addr[0]) ? bus_wdata[7:0] : bus_wdata[15:8];
  assign sram_map   = regs_q.sram[UNLOCK_BIT];
  assign unused_bits = ^{bus_addr[7:1], regs_q.sram[6:0], regs_q.mode[5:0]};

  rbm_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .sel    (bus_addr[11:8]),
    .wbyte  (wbyte),
    .regs_q (regs_q)
  );

  rbm_window_map #(.NUM_WIN(NUM_WIN)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .base     (regs_q.bank[IDX_LSB +: BANK_W]),
    .linear   (regs_q.mode[LINEAR_BIT]),
    .win_bank (win_bank)
  );

  rbm_io_read #(.IO_PAGE(IO_PAGE)) u_io (
    .clk   (clk),
    .rst_n (rst_n),
    .rd    (bus_rd),
    .page  (bus_addr[23:8]),
    .nib   (regs_q.bank[7:4]),
    .hit   (io_hit),
    .rdata (bus_rdata)
  );

  always_comb begin
    rom_bank = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (bus_addr[WIN_SHIFT +: BANK_W] == BANK_W'(i)) rom_bank = win_bank[i*BANK_W +: BANK_W];
    end
  end

  // R4: an accepted SRAM-byte write shows its bit 7 on sram_map next cycle
  p_sram_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && regs_q.mode[UNLOCK_BIT] && bus_addr[11:8] == SEL_SRAM) |=> sram_map == $past(wbyte[7]));

  // R2: high-address writes leave the SRAM flag alone
  p_high_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !low_region) |=> $stable(sram_map));
endmodule

// File: tb/rot_bank_mapper_tb_top.sv
module rot_bank_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        io_hit, sram_map;
  logic [23:0] win_bank;
  logic [2:0]  rom_bank;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rot_bank_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .io_hit(io_hit),
    .sram_map(sram_map), .win_bank(win_bank), .rom_bank(rom_bank)
  );

  typedef struct packed {
    logic [23:0] addr;
    logic [15:0] data;
    logic        wide;
    logic        sram;
    logic [2:0]  idx;
    logic        lin;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{24'h000F01, 16'h0030, 1'b0, 1'b0, 3'd3, 1'b0, 4'd5},  // R5 index 3, single
    '{24'h000E01, 16'h00C0, 1'b0, 1'b0, 3'd3, 1'b1, 4'd6},  // R6 linear from 3
    '{24'h000D01, 16'h1280, 1'b1, 1'b1, 3'd3, 1'b1, 4'd8},  // R8 wide, low byte; R4
    '{24'h000F00, 16'hAB70, 1'b1, 1'b1, 3'd7, 1'b1, 4'd8},  // R8 wide at even addr
    '{24'h000C01, 16'h0000, 1'b0, 1'b1, 3'd7, 1'b1, 4'd2},  // R2 bad selector
    '{24'h010F01, 16'h0000, 1'b0, 1'b1, 3'd7, 1'b1, 4'd2},  // R2 above 64 KB
    '{24'h000E00, 16'h8000, 1'b0, 1'b1, 3'd7, 1'b0, 4'd8},  // R8 even byte lane
    '{24'h000F01, 16'h55D0, 1'b0, 1'b1, 3'd5, 1'b0, 4'd5},  // R5 bit7 ignored for index
    '{24'h000D01, 16'h007F, 1'b0, 1'b0, 3'd5, 1'b0, 4'd4}   // R4 SRAM off
  };

  function automatic logic [23:0] exp_win(input logic [2:0] idx, input logic lin);
    logic [23:0] v;
    for (int i = 0; i < 8; i++) v[i*3 +: 3] = lin ? idx + 3'(i) : idx;
    return v;
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [23:0] a, input logic [15:0] d, input logic w);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wide = w; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic do_read(input logic [23:0] a, input logic strobe);
    @(negedge clk);
    bus_addr = a; bus_rd = strobe;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic chk_reset_state();
    chk(sram_map == 1'b0, "R1", "sram_map", 32'(sram_map), 0);
    chk(win_bank == 24'h0, "R1", "win_bank", 32'(win_bank), 0);
    do_read(24'hA13000, 1'b1);
    chk(io_hit && bus_rdata == 16'h0000, "R1", "readback", 32'(bus_rdata), 0);
    bus_rd = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk_reset_state();

    for (int k = 0; k < NV; k++) begin
      do_write(VECS[k].addr, VECS[k].data, VECS[k].wide);
      chk(win_bank == exp_win(VECS[k].idx, VECS[k].lin), $sformatf("R%0d", VECS[k].req),
          $sformatf("vec %0d win_bank", k), 32'(win_bank), 32'(exp_win(VECS[k].idx, VECS[k].lin)));
      chk(sram_map == VECS[k].sram, $sformatf("R%0d", VECS[k].req),
          $sformatf("vec %0d sram_map", k), 32'(sram_map), 32'(VECS[k].sram));
    end

    // R7 readback and misses
    do_read(24'hA13055, 1'b1);
    chk(io_hit == 1'b1, "R7", "hit in page", 32'(io_hit), 1);
    chk(bus_rdata == 16'h00D0, "R7", "readback value", 32'(bus_rdata), 32'h00D0);
    do_read(24'hA13100, 1'b1);
    chk(!io_hit && bus_rdata == 0, "R7", "above page", 32'(bus_rdata), 0);
    do_read(24'hA12FFF, 1'b1);
    chk(!io_hit && bus_rdata == 0, "R7", "below page", 32'(bus_rdata), 0);
    do_read(24'hA13000, 1'b0);
    chk(!io_hit, "R7", "no strobe", 32'(io_hit), 0);

    // R3 lock and linear in the same write
    do_write(24'h000E01, 16'h0040, 1'b0);
    chk(win_bank == exp_win(3'd5, 1'b1), "R3", "lock write applied", 32'(win_bank),
        32'(exp_win(3'd5, 1'b1)));
    // R9 window select under current address
    do_read(24'h0C0000, 1'b0);
    chk(rom_bank == 3'd0, "R9", "window 3 bank", 32'(rom_bank), 0);
    do_read(24'h1FFFFF, 1'b0);
    chk(rom_bank == 3'd4, "R9", "window 7 bank", 32'(rom_bank), 4);
    do_write(24'h000F01, 16'h0000, 1'b0);
    chk(win_bank == exp_win(3'd5, 1'b1), "R3", "bank write locked", 32'(win_bank),
        32'(exp_win(3'd5, 1'b1)));
    do_write(24'h000E01, 16'h0080, 1'b0);
    do_write(24'h000D01, 16'h0080, 1'b0);
    chk(sram_map == 1'b0, "R3", "sram write locked", 32'(sram_map), 0);
    chk(win_bank == exp_win(3'd5, 1'b1), "R3", "mode write locked", 32'(win_bank),
        32'(exp_win(3'd5, 1'b1)));
    do_read(24'hA13001, 1'b1);
    chk(bus_rdata == 16'h00D0, "R7", "readback while locked", 32'(bus_rdata), 32'h00D0);
    bus_rd = 1'b0;

    // R1 reset clears the lock; R10 next-cycle effect
    do_reset();
    chk_reset_state();
    do_write(24'h000F01, 16'h0010, 1'b0);
    chk(win_bank == exp_win(3'd1, 1'b0), "R10", "unlocked after reset", 32'(win_bank),
        32'(exp_win(3'd1, 1'b0)));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule